// File: doc/BRIEF.md
# Quad-Port Synchronous RAM

This block is a parameterized storage array with two write ports (A and B) and two read ports (A and B), all active at the same time. Each port has its own address, enable, clock enable and pair of clears. The block takes two clocks: an input-side clock and an output-side clock. The write ports and the array run on the input-side clock. Each read port can place its registers on either clock.

Each signal group is given a timing choice at elaboration: the write group of a port (enable, address, data), the read address of a port, the read enable of a port, and the read data output of a port. The choices are an extra register on the input-side clock, a register on the output-side clock, or a straight path. Each registered group can also be tied to the input-side clear or the output-side clear of its port, or to neither. Elaboration stops with an error for a combination that makes no sense, such as a clear on an unregistered group or a write group on the output-side clock.

A registered read output loads only while its read enable is high. It keeps showing the last word read while the enable is low, which lets a consumer stall a read port without extra buffering.

Top module: `quad_port_ram`

## Requirements
- R1: A write port changes the array only if its write enable and its input-side clock enable are both high at the input-clock rising edge that samples them. With either one low, the array is unchanged.
- R2: An unregistered write group commits on the edge that samples it. A write group registered on the input clock commits one input-clock edge later.
- R3: When both write ports reach the array on the same edge with the same address, the word takes port A's data.
- R4: A registered read output loads the addressed word only on an edge of its selected clock where that clock's enable for the port and the effective read enable are both high. Otherwise it holds the last word read.
- R5: On a registered read output, a read of a word that is being written on the same edge returns the word's previous contents. The new data appears on the following load.
- R6: An unregistered read output follows the word at the effective read address combinationally, and its read enable has no effect on it.
- R7: With the read address registered on the input clock and the output registered on the output clock (both clocks tied together), read data appears two edges after the address and enable are presented.
- R8: Clears are asynchronous and active high, and drive the registers tied to them to zero. While an output-side clear is high, a registered read output is zero. An input-side clear on a registered write group cancels the write it holds.
- R9: The depth defaults to two to the power of the address width. Both the lowest address (0) and the highest address (depth minus one) store and return data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input-side clock; array and write ports |
| clk_out | input | 1 | Output-side clock for read registers placed on it |
| ce_in_a | input | 1 | Input-side clock enable, port A |
| ce_in_b | input | 1 | Input-side clock enable, port B |
| ce_out_a | input | 1 | Output-side clock enable, port A |
| ce_out_b | input | 1 | Output-side clock enable, port B |
| clr_in_a | input | 1 | Input-side asynchronous clear, port A |
| clr_in_b | input | 1 | Input-side asynchronous clear, port B |
| clr_out_a | input | 1 | Output-side asynchronous clear, port A |
| clr_out_b | input | 1 | Output-side asynchronous clear, port B |
| we_a | input | 1 | Write enable, port A |
| wr_addr_a | input | AW | Write address, port A |
| wr_data_a | input | DW | Write data, port A |
| we_b | input | 1 | Write enable, port B |
| wr_addr_b | input | AW | Write address, port B |
| wr_data_b | input | DW | Write data, port B |
| rd_en_a | input | 1 | Read enable, port A |
| rd_addr_a | input | AW | Read address, port A |
| rd_en_b | input | 1 | Read enable, port B |
| rd_addr_b | input | AW | Read address, port B |
| q_a | output | DW | Read data, port A |
| q_b | output | DW | Read data, port B |

## Verification
The properties assume that every clear tied to a checked register is high on the first edges. Until then, the hold, latency and clear rules have no defined starting state. The bench meets this by raising all four clears at time zero, and it pulses clears only between sampling edges. The stalled-output and address-latency properties also assume that the clock pair seen by a read port is the one its parameters select. The bench drives both clock inputs from one source, so every edge-count expectation refers to a single clock. Stimulus changes only on falling edges, and reads target only words that have already been written, so no expected value depends on uninitialised storage.

// File: rtl/qpram_pkg.sv
`timescale 1ns/1ps
package qpram_pkg;
  // Which clock, if any, registers a signal group.
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_IN   = 2'd1,
    SEL_OUT  = 2'd2
  } stage_sel_e;

  // Which asynchronous clear, if any, resets a registered group.
  typedef enum logic [1:0] {
    CLR_NONE = 2'd0,
    CLR_IN   = 2'd1,
    CLR_OUT  = 2'd2
  } clr_sel_e;
endpackage

// File: rtl/qpram_stage.sv
`timescale 1ns/1ps
// One optional pipeline stage: pass-through, or a register on either clock
// with an optional asynchronous clear and a load qualifier.
module qpram_stage
  import qpram_pkg::*;
#(
  parameter int         W   = 8,
  parameter stage_sel_e SEL = SEL_NONE,
  parameter clr_sel_e   CLR = CLR_NONE
) (
  input  logic         clk_in,
  input  logic         clk_out,
  input  logic         ce_in,
  input  logic         ce_out,
  input  logic         clr_in,
  input  logic         clr_out,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam logic USE_OUT = (SEL == SEL_OUT);

  logic clk_s;
  logic ce_s;
  logic clr_s;
  logic unused_stage;

  assign clk_s = USE_OUT ? clk_out : clk_in;
  assign ce_s  = USE_OUT ? ce_out  : ce_in;
  assign clr_s = (CLR == CLR_IN)  ? clr_in  :
                 (CLR == CLR_OUT) ? clr_out : 1'b0;
  assign unused_stage = ^{clk_in, clk_out, ce_in, ce_out, clr_in, clr_out, en};

  generate
    if (SEL == SEL_NONE) begin : g_thru
      if (CLR != CLR_NONE) begin : g_bad_clr
        $error("qpram_stage: a clear is selected for an unregistered group");
      end
      assign q = d;
    end else begin : g_reg
      logic [W-1:0] r;
      always_ff @(posedge clk_s or posedge clr_s) begin
        if (clr_s)           r <= '0;
        else if (ce_s && en) r <= d;
      end
      assign q = r;
    end
  endgenerate
endmodule

// File: rtl/qpram_wr_path.sv
`timescale 1ns/1ps
// Write group of one port. The enable is qualified by the clock enable
// before the optional stage, so a held register never replays a write.
module qpram_wr_path
  import qpram_pkg::*;
#(
  parameter int         AW  = 6,
  parameter int         DW  = 16,
  parameter stage_sel_e SEL = SEL_IN,
  parameter clr_sel_e   CLR = CLR_IN
) (
  input  logic          clk_in,
  input  logic          ce_in,
  input  logic          clr_in,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  localparam int GW = 1 + AW + DW;

  generate
    if (SEL == SEL_OUT) begin : g_bad_sel
      $error("qpram_wr_path: write groups may only use the input clock");
    end
    if (CLR == CLR_OUT) begin : g_bad_clr
      $error("qpram_wr_path: write groups may only use the input-side clear");
    end
  endgenerate

  logic [GW-1:0] grp_d;
  logic [GW-1:0] grp_q;

  assign grp_d = {we & ce_in, addr, data};

  qpram_stage #(.W(GW), .SEL(SEL), .CLR(CLR)) u_grp (
    .clk_in (clk_in),
    .clk_out(clk_in),
    .ce_in  (1'b1),
    .ce_out (1'b1),
    .clr_in (clr_in),
    .clr_out(1'b0),
    .en     (1'b1),
    .d      (grp_d),
    .q      (grp_q)
  );

  assign {we_o, addr_o, data_o} = grp_q;
endmodule

// File: rtl/qpram_rd_path.sv
`timescale 1ns/1ps
// Read port: optional address stage, optional enable stage and optional
// output register that holds its word while the read enable is low.
module qpram_rd_path
  import qpram_pkg::*;
#(
  parameter int         AW       = 6,
  parameter int         DW       = 16,
  parameter stage_sel_e ADDR_SEL = SEL_IN,
  parameter clr_sel_e   ADDR_CLR = CLR_IN,
  parameter stage_sel_e EN_SEL   = SEL_IN,
  parameter clr_sel_e   EN_CLR   = CLR_IN,
  parameter stage_sel_e Q_SEL    = SEL_OUT,
  parameter clr_sel_e   Q_CLR    = CLR_OUT
) (
  input  logic          clk_in,
  input  logic          clk_out,
  input  logic          ce_in,
  input  logic          ce_out,
  input  logic          clr_in,
  input  logic          clr_out,
  input  logic          rden,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] q,
  output logic          q_ld
);
  logic rden_eff;

  qpram_stage #(.W(AW), .SEL(ADDR_SEL), .CLR(ADDR_CLR)) u_addr (
    .clk_in(clk_in), .clk_out(clk_out), .ce_in(ce_in), .ce_out(ce_out),
    .clr_in(clr_in), .clr_out(clr_out), .en(1'b1), .d(addr), .q(addr_o)
  );

  qpram_stage #(.W(1), .SEL(EN_SEL), .CLR(EN_CLR)) u_en (
    .clk_in(clk_in), .clk_out(clk_out), .ce_in(ce_in), .ce_out(ce_out),
    .clr_in(clr_in), .clr_out(clr_out), .en(1'b1), .d(rden), .q(rden_eff)
  );

  qpram_stage #(.W(DW), .SEL(Q_SEL), .CLR(Q_CLR)) u_q (
    .clk_in(clk_in), .clk_out(clk_out), .ce_in(ce_in), .ce_out(ce_out),
    .clr_in(clr_in), .clr_out(clr_out), .en(rden_eff), .d(rdata), .q(q)
  );

  // Load strobe of the output register, brought out for the checker.
  assign q_ld = ((Q_SEL == SEL_OUT) ? ce_out : ce_in) & rden_eff;
endmodule

// File: rtl/qpram_array.sv
`timescale 1ns/1ps
// Storage array: two write ports on one clock, two asynchronous read taps.
// Port B is applied first and port A last, so A wins a same-address write.
module qpram_array #(
  parameter int AW    = 6,
  parameter int DW    = 16,
  parameter int DEPTH = 2 ** AW
) (
  input  logic          clk,
  input  logic          wa_en,
  input  logic [AW-1:0] wa_addr,
  input  logic [DW-1:0] wa_data,
  input  logic          wb_en,
  input  logic [AW-1:0] wb_addr,
  input  logic [DW-1:0] wb_data,
  input  logic [AW-1:0] ra_addr,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] ra_data,
  output logic [DW-1:0] rb_data
);
  localparam logic [AW:0] ADDR_LIM = (AW+1)'(DEPTH);

  logic [DW-1:0] mem [DEPTH];

  logic wa_ok;
  logic wb_ok;
  logic ra_ok;
  logic rb_ok;

  assign wa_ok = ({1'b0, wa_addr} < ADDR_LIM);
  assign wb_ok = ({1'b0, wb_addr} < ADDR_LIM);
  assign ra_ok = ({1'b0, ra_addr} < ADDR_LIM);
  assign rb_ok = ({1'b0, rb_addr} < ADDR_LIM);

  always_ff @(posedge clk) begin
    if (wb_en && wb_ok) mem[wb_addr] <= wb_data;
    if (wa_en && wa_ok) mem[wa_addr] <= wa_data;
  end

  assign ra_data = ra_ok ? mem[ra_addr] : '0;
  assign rb_data = rb_ok ? mem[rb_addr] : '0;
endmodule

// File: rtl/quad_port_ram.sv
`timescale 1ns/1ps
module quad_port_ram
  import qpram_pkg::*;
#(
  parameter int         AW          = 6,
  parameter int         DW          = 16,
  parameter int         DEPTH       = 2 ** AW,
  parameter stage_sel_e WR_A_SEL    = SEL_IN,
  parameter clr_sel_e   WR_A_CLR    = CLR_IN,
  parameter stage_sel_e WR_B_SEL    = SEL_IN,
  parameter clr_sel_e   WR_B_CLR    = CLR_IN,
  parameter stage_sel_e RA_ADDR_SEL = SEL_IN,
  parameter clr_sel_e   RA_ADDR_CLR = CLR_IN,
  parameter stage_sel_e RA_EN_SEL   = SEL_IN,
  parameter clr_sel_e   RA_EN_CLR   = CLR_IN,
  parameter stage_sel_e RA_Q_SEL    = SEL_OUT,
  parameter clr_sel_e   RA_Q_CLR    = CLR_OUT,
  parameter stage_sel_e RB_ADDR_SEL = SEL_IN,
  parameter clr_sel_e   RB_ADDR_CLR = CLR_IN,
  parameter stage_sel_e RB_EN_SEL   = SEL_IN,
  parameter clr_sel_e   RB_EN_CLR   = CLR_IN,
  parameter stage_sel_e RB_Q_SEL    = SEL_OUT,
  parameter clr_sel_e   RB_Q_CLR    = CLR_OUT
) (
  input  logic          clk_in,
  input  logic          clk_out,
  input  logic          ce_in_a,
  input  logic          ce_in_b,
  input  logic          ce_out_a,
  input  logic          ce_out_b,
  input  logic          clr_in_a,
  input  logic          clr_in_b,
  input  logic          clr_out_a,
  input  logic          clr_out_b,
  input  logic          we_a,
  input  logic [AW-1:0] wr_addr_a,
  input  logic [DW-1:0] wr_data_a,
  input  logic          we_b,
  input  logic [AW-1:0] wr_addr_b,
  input  logic [DW-1:0] wr_data_b,
  input  logic          rd_en_a,
  input  logic [AW-1:0] rd_addr_a,
  input  logic          rd_en_b,
  input  logic [AW-1:0] rd_addr_b,
  output logic [DW-1:0] q_a,
  output logic [DW-1:0] q_b
);
  generate
    if (DEPTH < 1 || DEPTH > 2 ** AW) begin : g_bad_depth
      $error("quad_port_ram: DEPTH must lie between 1 and 2**AW");
    end
  endgenerate

  logic          wa_en;
  logic [AW-1:0] wa_addr;
  logic [DW-1:0] wa_data;
  logic          wb_en;
  logic [AW-1:0] wb_addr;
  logic [DW-1:0] wb_data;
  logic [AW-1:0] ra_addr;
  logic [AW-1:0] rb_addr;
  logic [DW-1:0] ra_data;
  logic [DW-1:0] rb_data;
  logic          qa_ld;
  logic          qb_ld;

  qpram_wr_path #(.AW(AW), .DW(DW), .SEL(WR_A_SEL), .CLR(WR_A_CLR)) u_wr_a (
    .clk_in(clk_in), .ce_in(ce_in_a), .clr_in(clr_in_a),
    .we(we_a), .addr(wr_addr_a), .data(wr_data_a),
    .we_o(wa_en), .addr_o(wa_addr), .data_o(wa_data)
  );

  qpram_wr_path #(.AW(AW), .DW(DW), .SEL(WR_B_SEL), .CLR(WR_B_CLR)) u_wr_b (
    .clk_in(clk_in), .ce_in(ce_in_b), .clr_in(clr_in_b),
    .we(we_b), .addr(wr_addr_b), .data(wr_data_b),
    .we_o(wb_en), .addr_o(wb_addr), .data_o(wb_data)
  );

  qpram_array #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_array (
    .clk(clk_in),
    .wa_en(wa_en), .wa_addr(wa_addr), .wa_data(wa_data),
    .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
    .ra_addr(ra_addr), .rb_addr(rb_addr),
    .ra_data(ra_data), .rb_data(rb_data)
  );

  qpram_rd_path #(
    .AW(AW), .DW(DW),
    .ADDR_SEL(RA_ADDR_SEL), .ADDR_CLR(RA_ADDR_CLR),
    .EN_SEL(RA_EN_SEL), .EN_CLR(RA_EN_CLR),
    .Q_SEL(RA_Q_SEL), .Q_CLR(RA_Q_CLR)
  ) u_rd_a (
    .clk_in(clk_in), .clk_out(clk_out), .ce_in(ce_in_a), .ce_out(ce_out_a),
    .clr_in(clr_in_a), .clr_out(clr_out_a),
    .rden(rd_en_a), .addr(rd_addr_a), .rdata(ra_data),
    .addr_o(ra_addr), .q(q_a), .q_ld(qa_ld)
  );

  qpram_rd_path #(
    .AW(AW), .DW(DW),
    .ADDR_SEL(RB_ADDR_SEL), .ADDR_CLR(RB_ADDR_CLR),
    .EN_SEL(RB_EN_SEL), .EN_CLR(RB_EN_CLR),
    .Q_SEL(RB_Q_SEL), .Q_CLR(RB_Q_CLR)
  ) u_rd_b (
    .clk_in(clk_in), .clk_out(clk_out), .ce_in(ce_in_b), .ce_out(ce_out_b),
    .clr_in(clr_in_b), .clr_out(clr_out_b),
    .rden(rd_en_b), .addr(rd_addr_b), .rdata(rb_data),
    .addr_o(rb_addr), .q(q_b), .q_ld(qb_ld)
  );
endmodule

// File: rtl/qpram_chk.sv
`timescale 1ns/1ps
module qpram_chk
  import qpram_pkg::*;
#(
  parameter int         AW          = 6,
  parameter int         DW          = 16,
  parameter stage_sel_e WR_A_SEL    = SEL_IN,
  parameter clr_sel_e   WR_A_CLR    = CLR_IN,
  parameter stage_sel_e RA_ADDR_SEL = SEL_IN,
  parameter clr_sel_e   RA_ADDR_CLR = CLR_IN,
  parameter stage_sel_e RA_Q_SEL    = SEL_OUT,
  parameter clr_sel_e   RA_Q_CLR    = CLR_OUT,
  parameter stage_sel_e RB_Q_SEL    = SEL_OUT,
  parameter clr_sel_e   RB_Q_CLR    = CLR_OUT
) (
  input logic          clk_in,
  input logic          clk_out,
  input logic          clr_in_a,
  input logic          clr_out_a,
  input logic          clr_in_b,
  input logic          clr_out_b,
  input logic          ce_in_a,
  input logic          we_a,
  input logic [AW-1:0] rd_addr_a,
  input logic [AW-1:0] ra_addr,
  input logic          wa_en,
  input logic          qa_ld,
  input logic          qb_ld,
  input logic [DW-1:0] q_a,
  input logic [DW-1:0] q_b
);
  logic armed;
  initial armed = 1'b0;
  always @(posedge clk_in) armed <= 1'b1;

  logic qclk_a, qclk_b, qclr_a, qclr_b, aclr_a, wclr_a;
  assign qclk_a = (RA_Q_SEL == SEL_OUT) ? clk_out : clk_in;
  assign qclk_b = (RB_Q_SEL == SEL_OUT) ? clk_out : clk_in;
  assign qclr_a = (RA_Q_CLR == CLR_IN) ? clr_in_a : (RA_Q_CLR == CLR_OUT) ? clr_out_a : 1'b0;
  assign qclr_b = (RB_Q_CLR == CLR_IN) ? clr_in_b : (RB_Q_CLR == CLR_OUT) ? clr_out_b : 1'b0;
  assign aclr_a = (RA_ADDR_CLR == CLR_IN) ? clr_in_a : (RA_ADDR_CLR == CLR_OUT) ? clr_out_a : 1'b0;
  assign wclr_a = (WR_A_CLR == CLR_IN) ? clr_in_a : 1'b0;

  generate
    if (RA_Q_SEL != SEL_NONE) begin : g_hold_a
      assert_hold_a_R4: assert property (@(posedge qclk_a) disable iff (!armed || qclr_a)
        !qa_ld |=> $stable(q_a));
    end
    if (RB_Q_SEL != SEL_NONE) begin : g_hold_b
      assert_hold_b_R4: assert property (@(posedge qclk_b) disable iff (!armed || qclr_b)
        !qb_ld |=> $stable(q_b));
    end
    if (RA_Q_SEL != SEL_NONE && RA_Q_CLR != CLR_NONE) begin : g_clr_a
      assert_clear_a_R8: assert property (@(negedge qclk_a) disable iff (!armed)
        qclr_a |-> (q_a == '0));
    end
    if (RB_Q_SEL != SEL_NONE && RB_Q_CLR != CLR_NONE) begin : g_clr_b
      assert_clear_b_R8: assert property (@(negedge qclk_b) disable iff (!armed)
        qclr_b |-> (q_b == '0));
    end
    if (WR_A_SEL == SEL_IN) begin : g_wr_a
      assert_gated_write_R1: assert property (@(posedge clk_in) disable iff (!armed || wclr_a)
        !(we_a && ce_in_a) |=> !wa_en);
      assert_write_delay_R2: assert property (@(posedge clk_in) disable iff (!armed || wclr_a)
        (we_a && ce_in_a) |=> wa_en);
    end
    if (RA_ADDR_SEL == SEL_IN) begin : g_addr_a
      assert_addr_delay_R7: assert property (@(posedge clk_in) disable iff (!armed || aclr_a)
        ce_in_a |=> (ra_addr == $past(rd_addr_a)));
    end
  endgenerate
endmodule

bind quad_port_ram qpram_chk #(
  .AW(AW), .DW(DW),
  .WR_A_SEL(WR_A_SEL), .WR_A_CLR(WR_A_CLR),
  .RA_ADDR_SEL(RA_ADDR_SEL), .RA_ADDR_CLR(RA_ADDR_CLR),
  .RA_Q_SEL(RA_Q_SEL), .RA_Q_CLR(RA_Q_CLR),
  .RB_Q_SEL(RB_Q_SEL), .RB_Q_CLR(RB_Q_CLR)
) u_chk (
  .clk_in(clk_in), .clk_out(clk_out),
  .clr_in_a(clr_in_a), .clr_out_a(clr_out_a),
  .clr_in_b(clr_in_b), .clr_out_b(clr_out_b),
  .ce_in_a(ce_in_a), .we_a(we_a), .rd_addr_a(rd_addr_a),
  .ra_addr(ra_addr), .wa_en(wa_en),
  .qa_ld(qa_ld), .qb_ld(qb_ld), .q_a(q_a), .q_b(q_b)
);

// File: tb/quad_port_ram_test.sv
`timescale 1ns/1ps
module quad_port_ram_test;
  import qpram_pkg::*;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int TOP = (2 ** AW) - 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic ce_in_a = 1'b1, ce_in_b = 1'b1, ce_out_a = 1'b1, ce_out_b = 1'b1;
  logic clr_in_a = 1'b1, clr_in_b = 1'b1, clr_out_a = 1'b1, clr_out_b = 1'b1;
  logic we_a = 1'b0, we_b = 1'b0, rd_en_a = 1'b0, rd_en_b = 1'b0;
  logic [AW-1:0] wr_addr_a = '0, wr_addr_b = '0, rd_addr_a = '0, rd_addr_b = '0;
  logic [DW-1:0] wr_data_a = '0, wr_data_b = '0;
  logic [DW-1:0] q_a, q_b;

  // Port A: registered write, read address on input clock, output on output
  // clock. Port B: unregistered write, fully combinational read.
  quad_port_ram #(
    .AW(AW), .DW(DW),
    .WR_A_SEL(SEL_IN), .WR_A_CLR(CLR_IN),
    .WR_B_SEL(SEL_NONE), .WR_B_CLR(CLR_NONE),
    .RA_ADDR_SEL(SEL_IN), .RA_ADDR_CLR(CLR_IN),
    .RA_EN_SEL(SEL_NONE), .RA_EN_CLR(CLR_NONE),
    .RA_Q_SEL(SEL_OUT), .RA_Q_CLR(CLR_OUT),
    .RB_ADDR_SEL(SEL_NONE), .RB_ADDR_CLR(CLR_NONE),
    .RB_EN_SEL(SEL_NONE), .RB_EN_CLR(CLR_NONE),
    .RB_Q_SEL(SEL_NONE), .RB_Q_CLR(CLR_NONE)
  ) uut (
    .clk_in(clk), .clk_out(clk),
    .ce_in_a(ce_in_a), .ce_in_b(ce_in_b), .ce_out_a(ce_out_a), .ce_out_b(ce_out_b),
    .clr_in_a(clr_in_a), .clr_in_b(clr_in_b), .clr_out_a(clr_out_a), .clr_out_b(clr_out_b),
    .we_a(we_a), .wr_addr_a(wr_addr_a), .wr_data_a(wr_data_a),
    .we_b(we_b), .wr_addr_b(wr_addr_b), .wr_data_b(wr_data_b),
    .rd_en_a(rd_en_a), .rd_addr_a(rd_addr_a),
    .rd_en_b(rd_en_b), .rd_addr_b(rd_addr_b),
    .q_a(q_a), .q_b(q_b)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [DW-1:0] ref_mem [2**AW];

  typedef struct {
    int            due;
    logic [DW-1:0] exp;
    string         req;
  } sb_item_t;
  sb_item_t sb[$];
  sb_item_t it;

  always @(posedge clk) cyc++;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Monitor: compares port A output with scoreboard items when they fall due.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due == cyc) begin
      it = sb.pop_front();
      chk(it.req, q_a, it.exp);
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr_b(input logic [AW-1:0] a, input logic [DW-1:0] d);
    we_b = 1'b1; wr_addr_b = a; wr_data_b = d;
    tick();
    we_b = 1'b0;
    ref_mem[a] = d;
  endtask

  task automatic wr_a(input logic [AW-1:0] a, input logic [DW-1:0] d);
    we_a = 1'b1; wr_addr_a = a; wr_data_a = d;
    tick();
    we_a = 1'b0;
    tick();
    ref_mem[a] = d;
  endtask

  task automatic look_b(input string req, input logic [AW-1:0] a);
    rd_addr_b = a;
    #1;
    chk(req, q_b, ref_mem[a]);
  endtask

  // Driver: presents a port A read and queues its expected word, due two edges on.
  task automatic rd_a(input string req, input logic [AW-1:0] a);
    rd_en_a = 1'b1; rd_addr_a = a;
    sb.push_back('{cyc + 2, ref_mem[a], req});
    tick();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    tick(); tick();
    clr_in_a = 1'b0; clr_in_b = 1'b0; clr_out_a = 1'b0; clr_out_b = 1'b0;
    chk("R8 reset output", q_a, '0);
    tick();
    chk("R8 output stays clear with read disabled", q_a, '0);

    // R6 / R2 / R9: unregistered writes through B, seen on combinational read B.
    wr_b(6'd0, 16'h1234);
    look_b("R9 lowest address", 6'd0);
    wr_b(6'd5, 16'hA5A5);
    look_b("R6 combinational read", 6'd5);
    wr_b(TOP[AW-1:0], 16'hFFFF);
    look_b("R9 highest address", TOP[AW-1:0]);
    rd_en_b = 1'b0;
    look_b("R6 read enable has no effect", 6'd5);

    // R2: registered write on port A lands one edge after it is sampled.
    wr_b(6'd1, 16'h0000);
    we_a = 1'b1; wr_addr_a = 6'd1; wr_data_a = 16'h0F0F;
    tick();
    we_a = 1'b0;
    look_b("R2 registered write not yet committed", 6'd1);
    tick();
    ref_mem[1] = 16'h0F0F;
    look_b("R2 registered write committed", 6'd1);
    wr_a(6'd62, 16'hC3C3);
    look_b("R2 second registered write", 6'd62);

    // R1: clock enable low blocks writes on both ports.
    ce_in_a = 1'b0; we_a = 1'b1; wr_addr_a = 6'd5; wr_data_a = 16'hDEAD;
    tick(); tick();
    we_a = 1'b0; ce_in_a = 1'b1;
    tick();
    look_b("R1 port A write blocked by clock enable", 6'd5);
    ce_in_b = 1'b0; we_b = 1'b1; wr_addr_b = 6'd0; wr_data_b = 16'hBEEF;
    tick();
    we_b = 1'b0; ce_in_b = 1'b1;
    look_b("R1 port B write blocked by clock enable", 6'd0);

    // R3: both writes hit the array on the same edge; A is registered, so it
    // is presented one edge before B.
    we_a = 1'b1; wr_addr_a = 6'd10; wr_data_a = 16'hAAAA;
    tick();
    we_a = 1'b0;
    we_b = 1'b1; wr_addr_b = 6'd10; wr_data_b = 16'hBBBB;
    tick();
    we_b = 1'b0;
    ref_mem[10] = 16'hAAAA;
    look_b("R3 port A wins collision", 6'd10);
    wr_b(6'd10, 16'hBBBB);
    look_b("R3 port B alone writes the word", 6'd10);

    // R7: pipelined reads on port A, two edges of latency.
    rd_a("R7 read addr 0", 6'd0);
    rd_a("R7 read addr 5", 6'd5);
    rd_a("R7 read top", TOP[AW-1:0]);
    rd_a("R7 read addr 1", 6'd1);
    tick();

    // R4: hold while read enable is low, and while the output clock enable is low.
    rd_en_a = 1'b0; rd_addr_a = 6'd5;
    tick(); tick(); tick();
    chk("R4 hold with read enable low", q_a, ref_mem[1]);
    rd_en_a = 1'b1; ce_out_a = 1'b0;
    tick(); tick(); tick();
    chk("R4 hold with output clock enable low", q_a, ref_mem[1]);
    ce_out_a = 1'b1;
    tick(); tick();
    chk("R4 loads once enabled", q_a, ref_mem[5]);

    // R5: read and write of one word on the same edge.
    wr_b(6'd20, 16'h1111);
    rd_en_a = 1'b1; rd_addr_a = 6'd20;
    tick();
    we_b = 1'b1; wr_addr_b = 6'd20; wr_data_b = 16'h2222;
    sb.push_back('{cyc + 1, 16'h1111, "R5 old data on colliding read"});
    tick();
    we_b = 1'b0;
    ref_mem[20] = 16'h2222;
    sb.push_back('{cyc + 1, 16'h2222, "R5 new data on next load"});
    tick();

    // R8: output clear and cancelled pending write.
    clr_out_a = 1'b1;
    #1;
    chk("R8 output clear is immediate", q_a, '0);
    tick();
    chk("R8 output held clear across an edge", q_a, '0);
    clr_out_a = 1'b0;
    rd_en_a = 1'b0;
    wr_b(6'd30, 16'h3030);
    we_a = 1'b1; wr_addr_a = 6'd30; wr_data_a = 16'h9999;
    tick();
    we_a = 1'b0; clr_in_a = 1'b1;
    tick();
    clr_in_a = 1'b0;
    tick();
    look_b("R8 input clear cancels pending write", 6'd30);

    tick(); tick(); tick();
    done = 1'b1;
    finish_run();
  end
endmodule